// File: doc/BRIEF.md
# Converter Command Decoder with Data-Ready

This block is the digital command layer of a serial analog-to-digital converter. A byte-level I2C target front end sits in front of it. That front end delivers each byte that arrives in a write frame, signals while a write byte is still being shifted in, and asks for one byte at a time during a read frame. The block decodes the one-byte commands for reset, start/sync, power-down, result read and register read, and the two-byte register-write command. It holds a configuration register and computes a status byte.

The converter is modelled as a strobe that carries a 24-bit result. Every result is kept as the latest value and pulls the active-low data-ready output down. Reading a result takes two frames. A write frame carries the result-read command, and it loads a shift buffer. A separate read frame then returns that buffer, most significant byte first.

A result can finish while the result-read command byte is still arriving. In that case the block loads the value that was current when the byte began, and it leaves data-ready low after the read. The host can then tell that a newer result is waiting.

Top module: `adc_cmd_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, and afterwards until another event occurs, `cfg` is 00h, `drdy_n` is 1, `pwr_dn` is 0, `conv_go` is 0 and `rd_data` is 00h.
- R2: A command byte matching 0000011x returns the block to the state of R1. This clears the stored result, so a later result read returns three 00h bytes and `drdy_n` stays 1.
- R3: A command byte matching 0000100x raises `conv_go` for exactly the one cycle after the byte. It also clears `pwr_dn`.
- R4: A command byte matching 0000001x sets `pwr_dn` from the cycle after the byte. Only a reset or a start/sync command clears it.
- R5: After a command byte matching 0001xxxx, a read frame returns the loaded 24-bit result as bits 23:16, then 15:8, then 7:0. Any further byte in that frame is 00h. Each byte appears on `rd_data` in the cycle after its `rd_req`.
- R6: After a command byte matching 00100rxx, every byte of a read frame returns register r. Register 0 is `cfg`. Register 1 is the status byte: bit 7 is 1 while `drdy_n` is low, and bits 6:0 are 0.
- R7: A command byte matching 0100 00xx makes the next byte of the same write frame a data byte. That byte is stored in `cfg` and is never decoded as a command. If `wr_start` arrives first, the pending write is dropped. A command byte of 0100 01xx, 0100 10xx or 0100 11xx writes nothing.
- R8: `drdy_n` is low in the cycle after any `res_vld`.
- R9: `drdy_n` goes high after the third result byte of a read frame has been requested. This happens only if no result has arrived since the result-read command loaded the buffer.
- R10: A result whose `res_vld` comes while `rx_busy` is high for the result-read command byte, or in the cycle of that byte's `wr_vld`, is not loaded. The value current before the byte began is loaded instead, and `drdy_n` stays low after the three bytes.
- R11: A read frame returns 00h for every byte if the last command byte was none of the two read commands. This covers an undefined command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_start | input | 1 | Pulse at the start of a write frame |
| rx_busy | input | 1 | High while a write-frame byte is being shifted in |
| wr_vld | input | 1 | Pulse: a write-frame byte is complete |
| wr_data | input | 8 | Byte that comes with `wr_vld` |
| rd_start | input | 1 | Pulse at the start of a read frame; restarts the byte index |
| rd_req | input | 1 | Request for the next read-frame byte |
| res_vld | input | 1 | Converter result strobe |
| res_data | input | 24 | Converter result |
| cfg | output | 8 | Configuration register |
| conv_go | output | 1 | One-cycle start/sync pulse to the converter |
| pwr_dn | output | 1 | Power-down request |
| drdy_n | output | 1 | Data ready, active low |
| rd_data | output | 8 | Byte returned for the last `rd_req` |

## Verification
All outputs are registered. A corrupted internal state therefore shows up on a port at the next clock edge or at the next access that reads it. A wrong snapshot or stale flag stays hidden until the read frame that follows a result-read command. It then appears as wrong bytes on `rd_data`, or as a `drdy_n` level that differs after the third byte. A pending register write that has been lost or kept too long shows one byte later, as a `cfg` value that did not change or a command that was wrongly executed. The bench compares a behavioural model with every output on every clock. This catches each such divergence in the cycle it appears.

// File: rtl/adc_cmd_core.sv
module adc_cmd_core #(
  parameter int RES_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_start,
  input  logic             rx_busy,
  input  logic             wr_vld,
  input  logic [7:0]       wr_data,
  input  logic             rd_start,
  input  logic             rd_req,
  input  logic             res_vld,
  input  logic [RES_W-1:0] res_data,
  output logic [7:0]       cfg,
  output logic             conv_go,
  output logic             pwr_dn,
  output logic             drdy_n,
  output logic [7:0]       rd_data
);
  localparam int NB = RES_W / 8;
  localparam int IW = $clog2(NB + 1);

  typedef enum logic [1:0] {RM_NONE, RM_RES, RM_REG} rmode_t;

  logic [7:0]       cfg_q, rd_q;
  logic [RES_W-1:0] latest_q, snap_q, shift_q;
  logic             late_q, stale_q, wpend_q, rsel_q, pd_q, go_q, drdy_q;
  rmode_t           mode_q;
  logic [IW-1:0]    idx_q;

  logic c_rst, c_go, c_pd, c_rdat, c_rreg, c_wreg;
  logic [7:0] sel_byte;

  wire [RES_W-1:0] latest_n = res_vld ? res_data : latest_q;
  wire is_data  = wr_vld && wpend_q && !wr_start;
  wire is_cmd   = wr_vld && !is_data;
  wire [7:0] status = {!drdy_q, 7'd0};
  wire last_rd  = rd_req && (mode_q == RM_RES) && (idx_q == IW'(NB - 1));

  always_comb begin
    {c_rst, c_go, c_pd, c_rdat, c_rreg, c_wreg} = '0;
    casez (wr_data)
      8'b0000_011?: c_rst  = 1'b1;
      8'b0000_100?: c_go   = 1'b1;
      8'b0000_001?: c_pd   = 1'b1;
      8'b0001_????: c_rdat = 1'b1;
      8'b0010_0???: c_rreg = 1'b1;
      8'b0100_00??: c_wreg = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    sel_byte = 8'h00;
    case (mode_q)
      RM_RES:
        for (int k = 0; k < NB; k++)
          if (idx_q == IW'(k)) sel_byte = shift_q[(NB-1-k)*8 +: 8];
      RM_REG: sel_byte = rsel_q ? status : cfg_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (is_cmd && c_rst)) begin
      cfg_q    <= '0;
      rd_q     <= '0;
      latest_q <= '0;
      snap_q   <= '0;
      shift_q  <= '0;
      late_q   <= 1'b0;
      stale_q  <= 1'b0;
      wpend_q  <= 1'b0;
      rsel_q   <= 1'b0;
      pd_q     <= 1'b0;
      go_q     <= 1'b0;
      drdy_q   <= 1'b1;
      mode_q   <= RM_NONE;
      idx_q    <= '0;
    end else begin
      go_q     <= is_cmd && c_go;
      latest_q <= latest_n;
      stale_q  <= stale_q | res_vld;

      if (!rx_busy) begin
        snap_q <= latest_n;
        late_q <= 1'b0;
      end else if (res_vld) begin
        late_q <= 1'b1;
      end

      if (res_vld)                 drdy_q <= 1'b0;
      else if (last_rd && !stale_q) drdy_q <= 1'b1;

      if (wr_start) wpend_q <= 1'b0;
      if (is_data) begin
        wpend_q <= 1'b0;
        cfg_q   <= wr_data;
      end

      if (rd_start) idx_q <= '0;
      if (rd_req) begin
        rd_q <= sel_byte;
        if (idx_q != IW'(NB)) idx_q <= idx_q + 1'b1;
      end

      if (is_cmd) begin
        idx_q   <= '0;
        mode_q  <= RM_NONE;
        wpend_q <= c_wreg;
        if (c_go) pd_q <= 1'b0;
        if (c_pd) pd_q <= 1'b1;
        if (c_rdat) begin
          mode_q  <= RM_RES;
          shift_q <= snap_q;
          stale_q <= late_q | res_vld;
        end
        if (c_rreg) begin
          mode_q <= RM_REG;
          rsel_q <= wr_data[2];
        end
      end
    end
  end

  assign cfg     = cfg_q;
  assign conv_go = go_q;
  assign pwr_dn  = pd_q;
  assign drdy_n  = drdy_q;
  assign rd_data = rd_q;
endmodule

// File: rtl/adc_cmd_core_chk.sv
module adc_cmd_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_vld,
  input logic [7:0] wr_data,
  input logic       rd_req,
  input logic       res_vld,
  input logic [7:0] cfg,
  input logic       conv_go,
  input logic       pwr_dn,
  input logic       drdy_n,
  input logic [7:0] rd_data
);
  a_r8_drdy_low_after_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && !wr_vld |=> !drdy_n);

  a_r3_go_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go |=> !conv_go);

  a_r3_go_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go |-> $past(wr_vld));

  a_r4_pd_needs_command: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_dn) |-> $past(wr_vld) && ($past(wr_data[7:1]) == 7'b0000001));

  a_r9_drdy_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_n) |-> $past(rd_req) || $past(wr_vld));

  a_r7_cfg_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> $past(wr_vld));

  a_r5_rd_data_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $past(rd_req) || $past(wr_vld));
endmodule

bind adc_cmd_core adc_cmd_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_data(wr_data),
  .rd_req(rd_req), .res_vld(res_vld), .cfg(cfg), .conv_go(conv_go),
  .pwr_dn(pwr_dn), .drdy_n(drdy_n), .rd_data(rd_data)
);

// File: tb/test_adc_cmd_core.sv
`timescale 1ns/1ps
module test_adc_cmd_core;
  logic clk = 0, rst_n = 0;
  logic wr_start = 0, rx_busy = 0, wr_vld = 0, rd_start = 0, rd_req = 0, res_vld = 0;
  logic [7:0] wr_data = 0;
  logic [23:0] res_data = 0;
  logic [7:0] cfg, rd_data;
  logic conv_go, pwr_dn, drdy_n;

  int checks = 0, bad = 0;
  bit cmp_on = 0;
  logic [7:0] got [8];

  always #2 clk = ~clk;

  adc_cmd_core i_adc_cmd_core (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .rx_busy(rx_busy),
    .wr_vld(wr_vld), .wr_data(wr_data), .rd_start(rd_start), .rd_req(rd_req),
    .res_vld(res_vld), .res_data(res_data), .cfg(cfg), .conv_go(conv_go),
    .pwr_dn(pwr_dn), .drdy_n(drdy_n), .rd_data(rd_data)
  );

  // behavioural reference
  logic [7:0] e_cfg, e_rd;
  logic e_drdy_n, e_pd, e_go;
  int m_mode;            // 0 none, 1 result, 2 register
  bit m_sel, m_newer, m_hit, m_wait;
  logic [7:0] m_q [$];
  int m_ptr;
  logic [23:0] m_last, m_win;

  task automatic model_reset();
    e_cfg = 0; e_rd = 0; e_drdy_n = 1; e_pd = 0; e_go = 0;
    m_mode = 0; m_sel = 0; m_newer = 0; m_hit = 0; m_wait = 0;
    m_q = {}; m_ptr = 0; m_last = 0; m_win = 0;
  endtask

  always @(posedge clk) begin
    automatic bit dat, cmd;
    automatic logic [23:0] nl;
    automatic logic [23:0] old_win;
    automatic bit old_hit;
    if (!rst_n) model_reset();
    else begin
      dat = wr_vld && m_wait && !wr_start;
      cmd = wr_vld && !dat;
      if (cmd && wr_data[7:1] == 7'b0000011) model_reset();
      else begin
        old_win = m_win; old_hit = m_hit;
        nl = res_vld ? res_data : m_last;
        e_go = 0;
        if (rd_req) begin
          if (m_mode == 1) e_rd = (m_ptr < m_q.size()) ? m_q[m_ptr] : 8'h00;
          else if (m_mode == 2) e_rd = m_sel ? (e_drdy_n ? 8'h00 : 8'h80) : e_cfg;
          else e_rd = 8'h00;
          if (m_mode == 1 && m_ptr == 2 && !m_newer && !res_vld) e_drdy_n = 1;
          if (m_ptr < 3) m_ptr++;
        end
        if (rd_start) m_ptr = 0;
        if (res_vld) begin e_drdy_n = 0; m_newer = 1; end
        if (!rx_busy) begin m_win = nl; m_hit = 0; end
        else if (res_vld) m_hit = 1;
        m_last = nl;
        if (wr_start) m_wait = 0;
        if (dat) begin e_cfg = wr_data; m_wait = 0; end
        if (cmd) begin
          m_ptr = 0; m_mode = 0; m_wait = (wr_data[7:2] == 6'b010000);
          if (wr_data[7:1] == 7'b0000100) begin e_go = 1; e_pd = 0; end
          if (wr_data[7:1] == 7'b0000001) e_pd = 1;
          if (wr_data[7:4] == 4'b0001) begin
            m_mode = 1;
            m_q = {old_win[23:16], old_win[15:8], old_win[7:0]};
            m_newer = old_hit | res_vld;
          end
          if (wr_data[7:3] == 5'b00100) begin m_mode = 2; m_sel = wr_data[2]; end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R7 cfg vs model", {24'd0, cfg}, {24'd0, e_cfg});
    chk("R8 drdy_n vs model", {31'd0, drdy_n}, {31'd0, e_drdy_n});
    chk("R4 pwr_dn vs model", {31'd0, pwr_dn}, {31'd0, e_pd});
    chk("R3 conv_go vs model", {31'd0, conv_go}, {31'd0, e_go});
    chk("R5 rd_data vs model", {24'd0, rd_data}, {24'd0, e_rd});
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic frame(); wr_start = 1; tick(); wr_start = 0; endtask

  task automatic put(input logic [7:0] b, input int busy, input int res_at, input logic [23:0] rv);
    for (int i = 0; i < busy; i++) begin
      rx_busy = 1;
      if (i == res_at) begin res_vld = 1; res_data = rv; end
      tick();
      res_vld = 0;
    end
    rx_busy = 0; wr_vld = 1; wr_data = b; tick(); wr_vld = 0;
  endtask

  task automatic result(input logic [23:0] v);
    res_vld = 1; res_data = v; tick(); res_vld = 0;
  endtask

  task automatic rd_frame(input int n);
    rd_start = 1; tick(); rd_start = 0;
    for (int i = 0; i < n; i++) begin
      rd_req = 1; tick(); rd_req = 0; got[i] = rd_data; tick();
    end
  endtask

  task automatic rd_more(input int first, input int n);
    for (int i = first; i < first + n; i++) begin
      rd_req = 1; tick(); rd_req = 0; got[i] = rd_data; tick();
    end
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (4) tick();
    rst_n = 1; cmp_on = 1;
    tick();
    chk("R1 cfg", cfg, 0); chk("R1 drdy_n", drdy_n, 1);
    chk("R1 pwr_dn", pwr_dn, 0); chk("R1 conv_go", conv_go, 0); chk("R1 rd_data", rd_data, 0);

    rd_frame(2);
    chk("R11 no command byte0", got[0], 0); chk("R11 no command byte1", got[1], 0);

    result(24'hA1B2C3);
    chk("R8 drdy low", drdy_n, 0);
    frame(); put(8'h1F, 3, -1, 0);
    rd_frame(3);
    chk("R5 msb", got[0], 8'hA1); chk("R5 mid", got[1], 8'hB2); chk("R5 lsb", got[2], 8'hC3);
    chk("R9 drdy high after 3rd", drdy_n, 1);
    rd_more(3, 1);
    chk("R5 extra byte 00", got[3], 0);

    frame(); put(8'h43, 2, -1, 0); put(8'h5A, 2, -1, 0);
    chk("R7 cfg written", cfg, 8'h5A);
    frame(); put(8'h21, 2, -1, 0);
    rd_frame(2);
    chk("R6 cfg read 0", got[0], 8'h5A); chk("R6 cfg read 1", got[1], 8'h5A);
    frame(); put(8'h24, 1, -1, 0);
    rd_frame(1);
    chk("R6 status idle", got[0], 8'h00);
    frame(); put(8'h40, 1, -1, 0); put(8'h06, 1, -1, 0);
    chk("R7 data byte not reset", cfg, 8'h06);
    frame(); put(8'h44, 1, -1, 0); put(8'h33, 1, -1, 0);
    chk("R7 0100_01xx ignored", cfg, 8'h06);
    frame(); put(8'hFF, 1, -1, 0);
    rd_frame(1);
    chk("R11 undefined command", got[0], 0);
    frame(); put(8'h41, 1, -1, 0); frame(); put(8'h02, 1, -1, 0);
    chk("R7 dropped on new frame", cfg, 8'h06);
    chk("R4 powerdown via 0x02", pwr_dn, 1);

    frame(); put(8'h08, 1, -1, 0);
    chk("R3 go pulse", conv_go, 1); chk("R3 pd cleared", pwr_dn, 0);
    tick();
    chk("R3 go one cycle", conv_go, 0);
    frame(); put(8'h03, 1, -1, 0);
    chk("R4 pd set", pwr_dn, 1);
    frame(); put(8'h09, 0, -1, 0);
    chk("R3 go 0x09", conv_go, 1);

    result(24'h112233);
    frame(); put(8'h10, 1, -1, 0); rd_frame(3);
    chk("R9 prior read clears", drdy_n, 1);
    frame(); put(8'h10, 3, 1, 24'h445566);
    rd_frame(3);
    chk("R10 old msb", got[0], 8'h11); chk("R10 old lsb", got[2], 8'h33);
    chk("R10 drdy stays low", drdy_n, 0);
    frame(); put(8'h10, 0, -1, 0); rd_frame(3);
    chk("R10 new msb", got[0], 8'h44); chk("R10 new lsb", got[2], 8'h66);
    chk("R10 drdy high on new", drdy_n, 1);

    result(24'h778899);
    rx_busy = 0; wr_vld = 1; wr_data = 8'h1A; res_vld = 1; res_data = 24'hABCDEF; tick();
    wr_vld = 0; res_vld = 0;
    rd_frame(3);
    chk("R10 same-cycle old", got[0], 8'h77); chk("R10 same-cycle drdy", drdy_n, 0);

    frame(); put(8'h10, 0, -1, 0); rd_frame(1);
    result(24'h010203);
    rd_more(1, 2);
    chk("R9 arrival mid-read byte", got[1], 8'hCD); chk("R9 drdy stays low", drdy_n, 0);
    frame(); put(8'h26, 1, -1, 0); rd_frame(1);
    chk("R6 status pending", got[0], 8'h80);

    frame(); put(8'h42, 1, -1, 0); put(8'hC3, 1, -1, 0); put(8'h03, 1, -1, 0);
    frame(); put(8'h07, 1, -1, 0);
    chk("R2 cfg cleared", cfg, 0); chk("R2 drdy high", drdy_n, 1); chk("R2 pd cleared", pwr_dn, 0);
    frame(); put(8'h10, 1, -1, 0); rd_frame(3);
    chk("R2 result cleared 0", got[0], 0); chk("R2 result cleared 2", got[2], 0);
    chk("R2 drdy still high", drdy_n, 1);

    rst_n = 0; result(24'h123456); tick();
    chk("R1 drdy under reset", drdy_n, 1);
    rst_n = 1; tick();
    chk("R1 cfg after reset", cfg, 0);

    repeat (3) tick();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule